// File: doc/BRIEF.md
# SHA-256 Two-Round Compression Unit

This block advances a SHA-256 working state by two compression rounds for each accepted operation. The eight working words are split across two 128-bit operands. One operand carries the A, B, E and F words. The other carries the C, D, G and H words. A third 128-bit operand supplies the message-schedule word already summed with its round constant, one such sum per round. The block returns only the new A, B, E and F words, packed the same way as the input operand that carried them.

A full 64-round block is run as 32 chained operations. Because each round only shifts B, C, D, F, G and H, the A/B/E/F operand given to one operation is exactly the C/D/G/H operand needed by the next. A controller therefore feeds each result back as the new A/B/E/F operand, and the previous A/B/E/F operand becomes the new C/D/G/H operand. Schedule expansion, the constant table, padding and the final digest addition stay with the caller.

The result is registered. It appears one clock after `valid_in`, and `valid_out` marks it. A new operation may be accepted on every clock, so a chain can run back to back.

Top module: `sha2r_core`

## Requirements
- R1: Input lanes are fixed. `abef_in` holds A in [127:96], B in [95:64], E in [63:32] and F in [31:0]. `cdgh_in` holds C in [127:96], D in [95:64], G in [63:32] and H in [31:0]. The result on `abef_out` holds A in [127:96], B in [95:64], E in [63:32] and F in [31:0].
- R2: The first round uses the sum in `wk_in[31:0]`. The second round uses the sum in `wk_in[63:32]`.
- R3: `wk_in[127:64]` has no effect on the result.
- R4: Each round sets new A = Ch(E,F,G) + S1(E) + WK + H + Maj(A,B,C) + S0(A). Here Ch = (E&F)^(~E&G), Maj = (A&B)^(A&C)^(B&C), S0 = rotr2^rotr13^rotr22 and S1 = rotr6^rotr11^rotr25.
- R5: Each round sets new E = Ch(E,F,G) + S1(E) + WK + H + D. The other words shift: B gets old A, C gets old B, D gets old C, F gets old E, G gets old F and H gets old G. As a result, output B equals the A word after round one, and output F equals the E word after round one.
- R6: All additions wrap modulo 2^32.
- R7: `valid_out` is high in the cycle after a cycle with `valid_in` high, and low after a cycle with `valid_in` low. `abef_out` carries that operation's result.
- R8: While `valid_in` is low, `abef_out` holds its last value, whatever the other inputs do.
- R9: Synchronous active-high `rst` clears `valid_out`.
- R10: Thirty-two chained operations over the padded one-block message "abc", with the standard constants, followed by adding the standard initial hash, give the standard digest of "abc".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Accept an operation this cycle |
| abef_in | input | 128 | Working words A, B, E, F |
| cdgh_in | input | 128 | Working words C, D, G, H |
| wk_in | input | 128 | Low two lanes: W+K for round one, then round two |
| valid_out | output | 1 | Result on abef_out is fresh |
| abef_out | output | 128 | New A, B, E, F after two rounds |

## Verification
A wrong round-one value cannot hide. Output B is exactly A after round one, and output F is exactly E after round one, so such a fault shows on `abef_out` one clock after `valid_in`, in the same result word. A fault in the second round shows in that word's A or E lane. Any fault in a chained run also carries forward into every later operation and into the final "abc" digest. A lane swap or a wrong choice of round sum shows on the first operation of the chain, because the round-one and round-two sums differ there.

// File: rtl/sha2r_pkg.sv
package sha2r_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t a, b, c, d, e, f, g, h;
  } state_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t big_s0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_s1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction
endpackage

// File: rtl/sha2r_lanes.sv
module sha2r_lanes
  import sha2r_pkg::*;
(
  input  logic [LANES*WORD_W-1:0] abef_in,
  input  logic [LANES*WORD_W-1:0] cdgh_in,
  input  state_t                  st_res,
  output state_t                  st_init,
  output logic [LANES*WORD_W-1:0] abef_res
);
  localparam int L3 = 3 * WORD_W;
  localparam int L2 = 2 * WORD_W;
  localparam int L1 = WORD_W;

  always_comb begin
    st_init.a = abef_in[L3 +: WORD_W];
    st_init.b = abef_in[L2 +: WORD_W];
    st_init.e = abef_in[L1 +: WORD_W];
    st_init.f = abef_in[0  +: WORD_W];
    st_init.c = cdgh_in[L3 +: WORD_W];
    st_init.d = cdgh_in[L2 +: WORD_W];
    st_init.g = cdgh_in[L1 +: WORD_W];
    st_init.h = cdgh_in[0  +: WORD_W];
    abef_res  = {st_res.a, st_res.b, st_res.e, st_res.f};
  end
endmodule

// File: rtl/sha2r_round.sv
module sha2r_round
  import sha2r_pkg::*;
(
  input  state_t st_in,
  input  word_t  wk,
  output state_t st_out
);
  word_t t_e, t_a;

  always_comb begin
    t_e = st_in.h + big_s1(st_in.e) + choose(st_in.e, st_in.f, st_in.g) + wk;
    t_a = big_s0(st_in.a) + major(st_in.a, st_in.b, st_in.c);
    st_out.a = t_e + t_a;
    st_out.b = st_in.a;
    st_out.c = st_in.b;
    st_out.d = st_in.c;
    st_out.e = st_in.d + t_e;
    st_out.f = st_in.e;
    st_out.g = st_in.f;
    st_out.h = st_in.g;
  end

  // R4/R5: new A and new E differ only by S0+Maj minus old D (mod 2^32)
  always_comb begin
    a_r4_a_e_gap: assert (st_out.a - st_out.e ==
                          big_s0(st_in.a) + major(st_in.a, st_in.b, st_in.c) - st_in.d);
  end
endmodule

// File: rtl/sha2r_core.sv
module sha2r_core
  import sha2r_pkg::*;
#(
  parameter int ROUNDS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_in,
  input  logic [127:0] abef_in,
  input  logic [127:0] cdgh_in,
  input  logic [127:0] wk_in,
  output logic         valid_out,
  output logic [127:0] abef_out
);
  localparam int OPND_W = LANES * WORD_W;

  state_t             stage [ROUNDS+1];
  logic [OPND_W-1:0]  abef_next;
  logic [OPND_W-1:0]  abef_q;
  logic               vld_q;

  sha2r_lanes u_lanes (
    .abef_in  (abef_in),
    .cdgh_in  (cdgh_in),
    .st_res   (stage[ROUNDS]),
    .st_init  (stage[0]),
    .abef_res (abef_next)
  );

  for (genvar gi = 0; gi < ROUNDS; gi++) begin : g_rnd
    sha2r_round u_rnd (
      .st_in  (stage[gi]),
      .wk     (wk_in[gi*WORD_W +: WORD_W]),
      .st_out (stage[gi+1])
    );
  end

  // named internal events for the checks below
  word_t penult_a, penult_e;
  assign penult_a = stage[ROUNDS-1].a;
  assign penult_e = stage[ROUNDS-1].e;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= valid_in;
    if (valid_in) abef_q <= abef_next;
  end

  assign valid_out = vld_q;
  assign abef_out  = abef_q;

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  a_r7_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(abef_out));
  a_r5_b_is_prev_a: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> abef_out[95:64] == $past(penult_a));
  a_r5_f_is_prev_e: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> abef_out[31:0] == $past(penult_e));
endmodule

// File: tb/sha2r_core_test.sv
module sha2r_core_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         valid_in = 1'b0;
  logic [127:0] abef_in = '0, cdgh_in = '0, wk_in = '0;
  logic         valid_out;
  logic [127:0] abef_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sha2r_core uut (
    .clk(clk), .rst(rst), .valid_in(valid_in),
    .abef_in(abef_in), .cdgh_in(cdgh_in), .wk_in(wk_in),
    .valid_out(valid_out), .abef_out(abef_out)
  );

  localparam logic [31:0] KTAB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };
  localparam logic [255:0] HINIT =
    256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;
  localparam logic [255:0] ABC_DIGEST =
    256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  // bench's own restatement of two rounds, working on an 8-word array
  function automatic logic [127:0] model2(input logic [127:0] abef, input logic [127:0] cdgh,
                                          input logic [127:0] wk);
    logic [31:0] v [8];
    logic [31:0] s1, s0, c, m, x;
    v[0] = abef[127:96]; v[1] = abef[95:64]; v[2] = cdgh[127:96]; v[3] = cdgh[95:64];
    v[4] = abef[63:32];  v[5] = abef[31:0];  v[6] = cdgh[63:32];  v[7] = cdgh[31:0];
    for (int r = 0; r < 2; r++) begin
      s1 = rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25);
      s0 = rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22);
      c  = (v[4] & v[5]) | (~v[4] & v[6]);
      m  = (v[0] & v[1]) | (v[2] & (v[0] | v[1]));
      x  = c + s1 + v[7] + (r == 0 ? wk[31:0] : wk[63:32]);
      for (int k = 7; k > 0; k--) v[k] = v[k-1];
      v[4] = v[4] + x;
      v[0] = x + s0 + m;
    end
    return {v[0], v[1], v[4], v[5]};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0]  w [64];
    logic [127:0] abef, cdgh, exp, ref_a;
    logic [255:0] dig;

    // R9: reset state
    valid_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset clears valid_out", {127'd0, valid_out}, 128'd0);
    valid_in = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R7 idle valid_out low", {127'd0, valid_out}, 128'd0);

    // message schedule of padded "abc"
    for (int t = 0; t < 16; t++) w[t] = 32'd0;
    w[0] = 32'h61626380;
    w[15] = 32'h00000018;
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];

    // R1 R2 R4 R5 R6 R10: 32 chained back-to-back operations
    abef = {HINIT[255:224], HINIT[223:192], HINIT[127:96], HINIT[95:64]};
    cdgh = {HINIT[191:160], HINIT[159:128], HINIT[63:32], HINIT[31:0]};
    for (int i = 0; i < 32; i++) begin
      abef_in = abef;
      cdgh_in = cdgh;
      wk_in = {32'hdead0000 ^ i, 32'h5a5a5a5a + i, w[2*i+1] + KTAB[2*i+1], w[2*i] + KTAB[2*i]};
      valid_in = 1'b1;
      exp = model2(abef, cdgh, wk_in);
      @(negedge clk);
      chk("R7 valid_out after valid_in", {127'd0, valid_out}, 128'd1);
      chk("R4 R5 two-round result", abef_out, exp);
      cdgh = abef;
      abef = exp;
    end
    valid_in = 1'b0;
    dig = {abef[127:96] + HINIT[255:224], abef[95:64] + HINIT[223:192],
           cdgh[127:96] + HINIT[191:160], cdgh[95:64] + HINIT[159:128],
           abef[63:32] + HINIT[127:96],   abef[31:0] + HINIT[95:64],
           cdgh[63:32] + HINIT[63:32],    cdgh[31:0] + HINIT[31:0]};
    chk("R10 abc digest hi", dig[255:128], ABC_DIGEST[255:128]);
    chk("R10 abc digest lo", dig[127:0], ABC_DIGEST[127:0]);

    // R8: idle cycle with changing inputs keeps result
    ref_a = abef;
    abef_in = ~abef_in;
    cdgh_in = 128'h0123456789abcdef0123456789abcdef;
    wk_in = '1;
    @(negedge clk);
    chk("R7 valid_out low when idle", {127'd0, valid_out}, 128'd0);
    chk("R8 output held while idle", abef_out, ref_a);

    // R3: upper wk bits ignored
    abef_in = 128'h11111111_22222222_33333333_44444444;
    cdgh_in = 128'h55555555_66666666_77777777_88888888;
    wk_in = {64'd0, 32'h0badf00d, 32'hc0ffee00};
    exp = model2(abef_in, cdgh_in, wk_in);
    valid_in = 1'b1;
    @(negedge clk);
    chk("R3 upper wk zero", abef_out, exp);
    wk_in[127:64] = '1;
    @(negedge clk);
    chk("R3 upper wk ones", abef_out, exp);

    // R2: swapped round sums give a different, model-predicted answer
    wk_in = {64'd0, 32'hc0ffee00, 32'h0badf00d};
    @(negedge clk);
    chk("R2 round sum order", abef_out, model2(abef_in, cdgh_in, wk_in));

    // R6: all-ones operands wrap modulo 2^32
    abef_in = '1; cdgh_in = '1; wk_in = '1;
    @(negedge clk);
    chk("R6 wraparound all ones", abef_out, model2('1, '1, '1));

    // R1: zero state stays zero
    abef_in = '0; cdgh_in = '0; wk_in = '0;
    @(negedge clk);
    chk("R1 zero state", abef_out, 128'd0);

    // R1: only H nonzero lands in A and E lanes of round one, shifted by round two
    cdgh_in = 128'h00000000_00000000_00000000_00000001;
    @(negedge clk);
    chk("R1 lane placement", abef_out, model2(128'd0, cdgh_in, 128'd0));

    // R9: reset mid-stream
    rst = 1'b1;
    @(negedge clk);
    chk("R9 reset during traffic", {127'd0, valid_out}, 128'd0);
    rst = 1'b0;
    valid_in = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule